// File: doc/BRIEF.md
# Sparse Tag Decoder and Scatter Unit

This block sits on the consumer side of a structured-sparse operand format. A compressed operand comes as two equally shaped arrays: a stream of compressed values and a stream of 16-bit tag words. Each tag word holds four 4-bit dense indices, one for each lane of a group of four. For every element position the unit reads four tag/value pairs. They are read at a stride of the per-partition element count. The unit selects the nibble that belongs to the element's lane and splits that dense index into a row and a column using a configurable column count. It then hands out one scatter write (or accumulate) per pair on a valid/ready port toward a dense buffer.

A run begins with a one-cycle `start` pulse that latches the configuration. The active row count must be a multiple of four and must equal the supported row count (128). The column count must be nonzero. If any of these checks fails, the run is refused with a one-cycle `cfg_err` pulse and no reads or writes take place. A successful run ends with a one-cycle `done` pulse. The unit has no multiply-accumulate logic of its own: it only produces dense address/value pairs.

The controller is a state machine with these states:
- **IDLE**: waits for `start`, then goes to CHECK.
- **CHECK**: goes to FAULT on a bad configuration. Goes to COMPLETE at once when the element count is zero. Otherwise goes to FETCH.
- **FETCH**: issues one read, then goes to WAIT.
- **WAIT**: captures the tag word and value and loads the divider, then goes to DIVIDE.
- **DIVIDE**: repeatedly subtracts the column count until the remainder is below it, then goes to ISSUE.
- **ISSUE**: holds the scatter write until `sc_ready`. It then goes back to FETCH, or to COMPLETE after the last pair.
- **COMPLETE** (pulses `done`) and **FAULT** (pulses `cfg_err`): both return to IDLE.

Top module: `sparse_scatter_unit`

## Requirements
- R1: The dense index of a pair is bits [4·lane+3 : 4·lane] of the 16-bit tag word read for it, where lane is the two low bits of the element position (lane 0 = bits 3:0, lane 3 = bits 15:12).
- R2: For element position e, the four reads (part j = 0,1,2,3 in that order) use address (e >> 2) + j·stride. Element positions are processed in ascending order from 0, and each `rd_en` is a single-cycle pulse.
- R3: The scatter row is the dense index divided by the column count, and the scatter column is the index modulo the column count.
- R4: If the active row count is not a multiple of 4 or is not exactly 128, `cfg_err` pulses for one cycle and no read, scatter write or `done` follows.
- R5: A column count of zero is refused in the same way as R4.
- R6: While `sc_valid` is high and `sc_ready` is low, `sc_valid`, `sc_row`, `sc_col`, `sc_value` and `sc_acc` hold their values.
- R7: `done` is a single-cycle pulse in the cycle after the handshake of the final write. A run with zero element positions pulses `done` with no reads or writes.
- R8: `sc_value` is the value read at the same address as the tag word, and `sc_acc` equals the accumulate setting latched at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a run and latches the configuration (ignored while a run is active) |
| cfg_rows | input | ROW_W (9) | Active row count |
| cfg_cols | input | IDX_W+1 (5) | Column count used to split the dense index |
| cfg_elems | input | ELEM_W (10) | Number of element positions |
| cfg_stride | input | ADDR_W (10) | Per-partition element count (read stride) |
| cfg_acc | input | 1 | 1 = accumulate, 0 = overwrite |
| rd_en | output | 1 | Read strobe for the tag/value store |
| rd_addr | output | ADDR_W (10) | Read address |
| rd_tag | input | TAG_W (16) | Tag word, valid the cycle after `rd_en` |
| rd_val | input | VAL_W (8) | Compressed value, valid the cycle after `rd_en` |
| sc_valid | output | 1 | Scatter write valid |
| sc_ready | input | 1 | Scatter write accepted |
| sc_row | output | IDX_W (4) | Dense row |
| sc_col | output | IDX_W (4) | Dense column |
| sc_value | output | VAL_W (8) | Value to write |
| sc_acc | output | 1 | Accumulate rather than overwrite |
| done | output | 1 | Run finished |
| cfg_err | output | 1 | Run refused because of a bad configuration |

## Verification
On every cycle the assertions check these properties:
- the scatter outputs hold steady under back-pressure;
- every issued column is below the column count, and row·cols+col never exceeds 15;
- `done` and `rd_en` are single-cycle pulses;
- every `cfg_err` has a bad row or column count behind it, and no run completes with a bad configuration.

Some properties depend on the stored tag and value contents and on the run's history, so only the bench's scenarios can show them:
- the exact nibble chosen per lane;
- the strided address order;
- the quotient/remainder values;
- the pairing of each value with its tag;
- the complete absence of writes after a refused start.

// File: rtl/sparse_scatter_pkg.sv
`timescale 1ns/1ps
package sparse_scatter_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FETCH,
        ST_WAIT,
        ST_DIVIDE,
        ST_ISSUE,
        ST_COMPLETE,
        ST_FAULT
    } scat_state_e;
endpackage

// File: rtl/sparse_lane_extract.sv
`timescale 1ns/1ps
// Picks the 4-bit dense index of one lane out of a packed tag word.
module sparse_lane_extract #(
    parameter int TAG_W  = 16,
    parameter int LANES  = 4,
    parameter int IDX_W  = TAG_W / LANES,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic [TAG_W-1:0]  tag_word,
    input  logic [LANE_W-1:0] lane,
    output logic [IDX_W-1:0]  index
);
    logic [IDX_W-1:0] nibble [LANES];

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_nibble
            assign nibble[g] = tag_word[g*IDX_W +: IDX_W];
        end
    endgenerate

    assign index = nibble[lane];
endmodule

// File: rtl/sparse_addr_gen.sv
`timescale 1ns/1ps
// Read address = (element >> lane bits) + part * stride.
module sparse_addr_gen #(
    parameter int ELEM_W = 10,
    parameter int ADDR_W = 10,
    parameter int LANE_W = 2,
    parameter int PART_W = 2
) (
    input  logic [ELEM_W-1:0] elem,
    input  logic [PART_W-1:0] part,
    input  logic [ADDR_W-1:0] stride,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] offset;

    always_comb begin
        base   = ADDR_W'(elem >> LANE_W);
        offset = '0;
        for (int b = 0; b < PART_W; b++) begin
            if (part[b]) begin
                offset = offset + (stride << b);
            end
        end
        addr = base + offset;
    end
endmodule

// File: rtl/sparse_iter_divider.sv
`timescale 1ns/1ps
// Restoring divider by repeated subtraction: one subtract per cycle.
module sparse_iter_divider #(
    parameter int IDX_W = 4,
    parameter int DIV_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] dividend,
    input  logic [DIV_W-1:0] divisor,
    output logic [IDX_W-1:0] quotient,
    output logic [IDX_W-1:0] remainder,
    output logic             busy
);
    logic [DIV_W-1:0] rem_ext;

    assign rem_ext = {{(DIV_W-IDX_W){1'b0}}, remainder};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quotient  <= '0;
            remainder <= '0;
            busy      <= 1'b0;
        end else if (load) begin
            quotient  <= '0;
            remainder <= dividend;
            busy      <= 1'b1;
        end else if (busy) begin
            if (rem_ext >= divisor) begin
                remainder <= remainder - divisor[IDX_W-1:0];
                quotient  <= quotient + 1'b1;
            end else begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sparse_scatter_unit.sv
`timescale 1ns/1ps
module sparse_scatter_unit
    import sparse_scatter_pkg::*;
#(
    parameter int TAG_W       = 16,
    parameter int LANES       = 4,
    parameter int VAL_W       = 8,
    parameter int ELEM_W      = 10,
    parameter int ADDR_W      = 10,
    parameter int ACTIVE_ROWS = 128,
    parameter int ROW_W       = $clog2(ACTIVE_ROWS) + 2,
    parameter int IDX_W       = TAG_W / LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ROW_W-1:0]  cfg_rows,
    input  logic [IDX_W:0]    cfg_cols,
    input  logic [ELEM_W-1:0] cfg_elems,
    input  logic [ADDR_W-1:0] cfg_stride,
    input  logic              cfg_acc,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [VAL_W-1:0]  rd_val,
    output logic              sc_valid,
    input  logic              sc_ready,
    output logic [IDX_W-1:0]  sc_row,
    output logic [IDX_W-1:0]  sc_col,
    output logic [VAL_W-1:0]  sc_value,
    output logic              sc_acc,
    output logic              done,
    output logic              cfg_err
);
    localparam int LANE_W = $clog2(LANES);
    localparam int PART_W = $clog2(LANES);
    localparam int COL_W  = IDX_W + 1;

    scat_state_e state_q, state_d;

    logic [ROW_W-1:0]  rows_q;
    logic [COL_W-1:0]  cols_q;
    logic [ELEM_W-1:0] elems_q;
    logic [ADDR_W-1:0] stride_q;
    logic              acc_q;
    logic [ELEM_W-1:0] elem_q;
    logic [PART_W-1:0] part_q;
    logic [VAL_W-1:0]  val_q;

    logic              rows_misaligned;
    logic              rows_wrong;
    logic              cols_zero;
    logic              bad_cfg;
    logic              last_pair;
    logic              div_load;
    logic              div_busy;
    logic [IDX_W-1:0]  lane_index;
    logic [IDX_W-1:0]  quot;
    logic [IDX_W-1:0]  rem;

    // Configuration checks on latched values
    assign rows_misaligned = (rows_q[1:0] != 2'b00);
    assign rows_wrong      = (rows_q != ROW_W'(ACTIVE_ROWS));
    assign cols_zero       = (cols_q == '0);
    assign bad_cfg         = rows_misaligned || rows_wrong || cols_zero;
    assign last_pair       = (part_q == PART_W'(LANES - 1)) &&
                             (elem_q == elems_q - 1'b1);

    sparse_addr_gen #(
        .ELEM_W (ELEM_W),
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W),
        .PART_W (PART_W)
    ) u_addr (
        .elem   (elem_q),
        .part   (part_q),
        .stride (stride_q),
        .addr   (rd_addr)
    );

    sparse_lane_extract #(
        .TAG_W  (TAG_W),
        .LANES  (LANES),
        .IDX_W  (IDX_W),
        .LANE_W (LANE_W)
    ) u_lane (
        .tag_word (rd_tag),
        .lane     (elem_q[LANE_W-1:0]),
        .index    (lane_index)
    );

    sparse_iter_divider #(
        .IDX_W (IDX_W),
        .DIV_W (COL_W)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (div_load),
        .dividend  (lane_index),
        .divisor   (cols_q),
        .quotient  (quot),
        .remainder (rem),
        .busy      (div_busy)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_CHECK;
            ST_CHECK: begin
                if (bad_cfg)              state_d = ST_FAULT;
                else if (elems_q == '0)   state_d = ST_COMPLETE;
                else                      state_d = ST_FETCH;
            end
            ST_FETCH:    state_d = ST_WAIT;
            ST_WAIT:     state_d = ST_DIVIDE;
            ST_DIVIDE:   if (!div_busy) state_d = ST_ISSUE;
            ST_ISSUE: begin
                if (sc_ready) state_d = last_pair ? ST_COMPLETE : ST_FETCH;
            end
            ST_COMPLETE: state_d = ST_IDLE;
            ST_FAULT:    state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        rd_en    = 1'b0;
        div_load = 1'b0;
        sc_valid = 1'b0;
        done     = 1'b0;
        cfg_err  = 1'b0;
        unique case (state_q)
            ST_FETCH:    rd_en    = 1'b1;
            ST_WAIT:     div_load = 1'b1;
            ST_ISSUE:    sc_valid = 1'b1;
            ST_COMPLETE: done     = 1'b1;
            ST_FAULT:    cfg_err  = 1'b1;
            default:     ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rows_q   <= '0;
            cols_q   <= '0;
            elems_q  <= '0;
            stride_q <= '0;
            acc_q    <= 1'b0;
            elem_q   <= '0;
            part_q   <= '0;
            val_q    <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                rows_q   <= cfg_rows;
                cols_q   <= cfg_cols;
                elems_q  <= cfg_elems;
                stride_q <= cfg_stride;
                acc_q    <= cfg_acc;
                elem_q   <= '0;
                part_q   <= '0;
            end
            if (state_q == ST_WAIT) begin
                val_q <= rd_val;
            end
            if (state_q == ST_ISSUE && sc_ready) begin
                if (part_q == PART_W'(LANES - 1)) begin
                    part_q <= '0;
                    elem_q <= elem_q + 1'b1;
                end else begin
                    part_q <= part_q + 1'b1;
                end
            end
        end
    end

    assign sc_row   = quot;
    assign sc_col   = rem;
    assign sc_value = val_q;
    assign sc_acc   = acc_q;
endmodule

// File: rtl/sparse_scatter_chk.sv
`timescale 1ns/1ps
module sparse_scatter_chk #(
    parameter int IDX_W       = 4,
    parameter int VAL_W       = 8,
    parameter int ROW_W       = 9,
    parameter int ACTIVE_ROWS = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sc_valid,
    input logic             sc_ready,
    input logic [IDX_W-1:0] sc_row,
    input logic [IDX_W-1:0] sc_col,
    input logic [VAL_W-1:0] sc_value,
    input logic             sc_acc,
    input logic             done,
    input logic             cfg_err,
    input logic             rd_en,
    input logic [ROW_W-1:0] rows_q,
    input logic [IDX_W:0]   cols_q
);
    assert_hold_while_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid && !sc_ready) |=> (sc_valid && $stable(sc_row) && $stable(sc_col)
                                     && $stable(sc_value) && $stable(sc_acc)));

    assert_split_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid |-> (({1'b0, sc_col} < cols_q) &&
                      (int'(sc_row) * int'(cols_q) + int'(sc_col) <= 15)));

    assert_fault_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> ((rows_q != ROW_W'(ACTIVE_ROWS)) || (rows_q[1:0] != 2'b00) || (cols_q == '0)));

    assert_done_rows_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rows_q == ROW_W'(ACTIVE_ROWS)));

    assert_done_cols_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cols_q != '0));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_read_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);
endmodule

bind sparse_scatter_unit sparse_scatter_chk #(
    .IDX_W       (IDX_W),
    .VAL_W       (VAL_W),
    .ROW_W       (ROW_W),
    .ACTIVE_ROWS (ACTIVE_ROWS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sc_valid (sc_valid),
    .sc_ready (sc_ready),
    .sc_row   (sc_row),
    .sc_col   (sc_col),
    .sc_value (sc_value),
    .sc_acc   (sc_acc),
    .done     (done),
    .cfg_err  (cfg_err),
    .rd_en    (rd_en),
    .rows_q   (rows_q),
    .cols_q   (cols_q)
);

// File: tb/sparse_scatter_unit_test.sv
`timescale 1ns/1ps
module sparse_scatter_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [8:0]  cfg_rows = '0;
    logic [4:0]  cfg_cols = '0;
    logic [9:0]  cfg_elems = '0;
    logic [9:0]  cfg_stride = '0;
    logic        cfg_acc = 1'b0;
    logic        rd_en;
    logic [9:0]  rd_addr;
    logic [15:0] rd_tag;
    logic [7:0]  rd_val;
    logic        sc_valid;
    logic        sc_ready = 1'b0;
    logic [3:0]  sc_row;
    logic [3:0]  sc_col;
    logic [7:0]  sc_value;
    logic        sc_acc;
    logic        done;
    logic        cfg_err;

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] tag_mem [1024];
    logic [7:0]  val_mem [1024];

    always #5 clk = ~clk;

    sparse_scatter_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_rows(cfg_rows), .cfg_cols(cfg_cols), .cfg_elems(cfg_elems),
        .cfg_stride(cfg_stride), .cfg_acc(cfg_acc),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_tag(rd_tag), .rd_val(rd_val),
        .sc_valid(sc_valid), .sc_ready(sc_ready), .sc_row(sc_row), .sc_col(sc_col),
        .sc_value(sc_value), .sc_acc(sc_acc), .done(done), .cfg_err(cfg_err)
    );

    // Registered tag/value store: data valid the cycle after rd_en
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_tag <= tag_mem[rd_addr];
            rd_val <= val_mem[rd_addr];
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_case(input int rows, input int cols, input int n, input int stride,
                            input bit acc, input int rmode, input bit expect_err,
                            input string err_req);
        int  rk = 0;
        int  wk = 0;
        int  cyc = 0;
        bit  fin = 0;
        bit  seen_err = 0;
        bit  stalled = 0;
        int  s_row = 0, s_col = 0, s_val = 0;
        @(negedge clk);
        cfg_rows = 9'(rows); cfg_cols = 5'(cols); cfg_elems = 10'(n);
        cfg_stride = 10'(stride); cfg_acc = acc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!fin) begin
            if (stalled) begin
                check(sc_valid == 1'b1, "R6 valid held", int'(sc_valid), 1);
                check(int'(sc_row) == s_row && int'(sc_col) == s_col && int'(sc_value) == s_val,
                      "R6 data held", int'(sc_value), s_val);
            end
            sc_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 0);
            stalled = sc_valid && !sc_ready;
            s_row = int'(sc_row); s_col = int'(sc_col); s_val = int'(sc_value);
            if (rd_en) begin
                int e = rk / 4;
                int j = rk % 4;
                int ea = (e >> 2) + j * stride;
                check(int'(rd_addr) == ea, "R2 read address", int'(rd_addr), ea);
                rk++;
            end
            if (sc_valid && sc_ready) begin
                int e = wk / 4;
                int j = wk % 4;
                int a = (e >> 2) + j * stride;
                int idx = (int'(tag_mem[a]) >> (4 * (e % 4))) & 15;
                check(int'(sc_row) * cols + int'(sc_col) == idx, "R1 dense index",
                      int'(sc_row) * cols + int'(sc_col), idx);
                check(int'(sc_row) == idx / cols, "R3 row", int'(sc_row), idx / cols);
                check(int'(sc_col) == idx % cols, "R3 col", int'(sc_col), idx % cols);
                check(int'(sc_value) == int'(val_mem[a]), "R8 value", int'(sc_value), int'(val_mem[a]));
                check(sc_acc == acc, "R8 acc flag", int'(sc_acc), int'(acc));
                wk++;
            end
            if (done) begin
                check(wk == n * 4, "R7 writes before done", wk, n * 4);
                check(rk == n * 4, "R2 read count", rk, n * 4);
                fin = 1;
            end
            if (cfg_err) begin
                seen_err = 1;
                fin = 1;
            end
            cyc++;
            if (cyc > 3000) begin
                check(1'b0, "timeout", cyc, 3000);
                fin = 1;
            end
            @(negedge clk);
        end
        sc_ready = 1'b0;
        check(!done, "R7 done is one cycle", int'(done), 0);
        if (expect_err) begin
            check(seen_err, err_req, int'(seen_err), 1);
            check(wk == 0 && rk == 0, err_req, wk + rk, 0);
            repeat (3) begin
                check(!sc_valid && !done && !rd_en, err_req, int'(sc_valid), 0);
                @(negedge clk);
            end
        end else begin
            check(!seen_err, "R4 no error on good config", int'(seen_err), 0);
        end
    endtask

    task automatic test_reset();
        check(!sc_valid, "R6 reset valid", int'(sc_valid), 0);
        check(!done, "R7 reset done", int'(done), 0);
        check(!cfg_err, "R4 reset err", int'(cfg_err), 0);
        check(!rd_en, "R2 reset read", int'(rd_en), 0);
    endtask

    task automatic test_basic();        // R1 R2 R3 R8
        run_case(128, 4, 8, 5, 1'b0, 0, 1'b0, "");
    endtask

    task automatic test_backpressure(); // R6 R8
        run_case(128, 3, 6, 2, 1'b1, 1, 1'b0, "");
    endtask

    task automatic test_divisors();     // R3 edges
        run_case(128, 1, 4, 7, 1'b0, 0, 1'b0, "");
        run_case(128, 16, 5, 3, 1'b1, 1, 1'b0, "");
        run_case(128, 7, 9, 11, 1'b0, 0, 1'b0, "");
    endtask

    task automatic test_bad_rows();     // R4
        run_case(126, 4, 4, 2, 1'b0, 0, 1'b1, "R4 rows not multiple of 4");
        run_case(132, 4, 4, 2, 1'b0, 0, 1'b1, "R4 rows not 128");
        run_case(64, 4, 4, 2, 1'b0, 0, 1'b1, "R4 rows 64");
    endtask

    task automatic test_zero_cols();    // R5
        run_case(128, 0, 4, 2, 1'b0, 0, 1'b1, "R5 zero columns");
    endtask

    task automatic test_empty();        // R7
        run_case(128, 4, 0, 2, 1'b0, 0, 1'b0, "");
    endtask

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int a = 0; a < 1024; a++) begin
            tag_mem[a] = 16'((a * 40503) ^ 23100);
            val_mem[a] = 8'(a * 7 + 3);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_basic();
        test_backpressure();
        test_divisors();
        test_bad_rows();
        test_zero_cols();
        test_empty();
        test_basic();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule